// File: doc/BRIEF.md
# Bit-serial HDLC receive deframer

This block sits behind a synchronous serial line receiver. It sees one line bit per cycle in which `bit_en` is high. It searches for the flag pattern `01111110` to find frame boundaries and removes the zeros that the transmitter inserted after runs of five ones. It then packs the body bits into octets, taking the first received bit as bit 0. Octets leave on a byte stream. `out_sof` marks the first octet of a frame. A separate `out_end` strobe, which carries no data, gives a four-bit status word for the frame.

The frame check sequence is verified with the residue method. The register is preset to all ones, every body bit including the received check bits is shifted through it, and the result is compared with the fixed error-free remainder: 0x1D0F for the 16-bit check and 0xC704DD7B for the 32-bit check. The closing flag is the only sign that the check bits have ended, so the last `FCS_W/8` octets of each frame are held back and are never delivered. A frame can only be judged when it ends. Downstream logic therefore buffers the delivered octets and drops them if the status word is non-zero.

The controller has three states. HUNT means no synchronisation. SYNC means a flag has been seen and no body bit has arrived yet. BODY means body bits are being received. The transitions are:
- HUNT→SYNC on a flag.
- SYNC→SYNC on a repeated flag, which produces no output.
- SYNC→HUNT on an abort.
- SYNC→BODY on the first body bit.
- BODY→SYNC on the closing flag, which also opens the next frame; the end strobe is issued.
- BODY→HUNT on an abort; the end strobe is issued with the abort bit set.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: Before the first flag after reset, and after an abort until the next flag, line bits produce no output of any kind.
- R2: A 0 bit received directly after five consecutive 1 bits inside a frame is discarded, so body octets 0xFF, 0x7E and 0x3E arrive intact.
- R3: Body octets are delivered in arrival order. The first received bit of each octet is bit 0. `out_sof` is high only with the first delivered octet of a frame.
- R4: The last `FCS_W/8` complete octets before the closing flag, which are the check bytes, are never delivered. A frame of N body bits yields floor(N/8) − FCS_W/8 octets, or none.
- R5: At the closing flag, status bit 0 is set if and only if the residue after all body bits differs from 0x1D0F (16-bit check) or 0xC704DD7B (32-bit check). `out_stat` is zero whenever `out_end` is low.
- R6: Seven consecutive 1 bits end the current frame with an `out_end` whose status is exactly 4'b0010 (bit 1, abort). The receiver then returns to HUNT.
- R7: Status bit 2 (short) is set when the frame holds fewer than FCS_W+16 body bits, i.e. 32 or 48.
- R8: Status bit 3 (misaligned) is set when the body bit count is not a multiple of 8.
- R9: Consecutive flags with no body bits between them produce no output. One flag closes a frame and opens the next.
- R10: During and right after reset, `out_valid`, `out_sof`, `out_end` and `out_stat` are all zero.
- R11: `bit_in` is ignored in cycles where `bit_en` is low. Each output pulse follows a strobed bit by one cycle.
- R12: With `FCS_W` = 32, frames are checked against the 32-bit residue, the short limit is 48 bits and four octets are held back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Line bit strobe |
| bit_in | input | 1 | Line bit, valid when `bit_en` is high |
| out_valid | output | 1 | `out_data` holds a body octet |
| out_data | output | 8 | Body octet |
| out_sof | output | 1 | First octet of a frame |
| out_end | output | 1 | End-of-frame strobe, never together with `out_valid` |
| out_stat | output | 4 | Status at `out_end`: bit 0 check error, bit 1 abort, bit 2 short, bit 3 misaligned |

## Verification
The checker assumes that `bit_en` is low throughout reset, because the strobe property looks one cycle back. The bench therefore holds the strobe low until reset is released. It also assumes that a frame body and an end strobe cannot come from the same line bit. This holds because an accepted bit and a flag or abort need different run lengths of ones. The stimulus strobes every second cycle and drives the inverted bit in the idle cycles between strobes, so that any sampling of `bit_in` without the strobe would corrupt frames. All frame bodies are stuffed by a bench-side encoder, and aborts are sent as raw runs of eight ones.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    typedef enum logic [1:0] {
        S_HUNT = 2'd0,
        S_SYNC = 2'd1,
        S_BODY = 2'd2
    } rx_state_e;

    // status bit positions on out_stat
    localparam int ST_CRC   = 0;
    localparam int ST_ABORT = 1;
    localparam int ST_SHORT = 2;
    localparam int ST_ALIGN = 3;
    localparam int ST_W     = 4;

    // accepted bits of a flag that reach the delay line before it is recognised
    localparam int FLAG_DELAY = 6;

    function automatic logic [31:0] crc_poly(input int w);
        return (w == 32) ? 32'h04C1_1DB7 : 32'h0000_1021;
    endfunction

    function automatic logic [31:0] crc_residue(input int w);
        return (w == 32) ? 32'hC704_DD7B : 32'h0000_1D0F;
    endfunction

endpackage

// File: rtl/hdlc_rx_line.sv
// Run-length tracking of ones, flag/abort/stuff classification and the
// delay line that keeps the flag's own leading bits out of the body.
module hdlc_rx_line #(
    parameter int DLY = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bit_in,
    output logic flag_ev,
    output logic abort_ev,
    output logic body_ev,
    output logic body_bit
);
    localparam int FW = $clog2(DLY + 1);
    localparam logic [FW-1:0] FULL = FW'(DLY);

    logic [2:0]     ones;
    logic [DLY-1:0] dly;
    logic [FW-1:0]  fill;
    logic           accept;

    // fewer than five ones before: a data bit (possibly part of a flag)
    assign accept   = bit_en && (ones < 3'd5);
    assign flag_ev  = bit_en && !bit_in && (ones == 3'd6);
    assign abort_ev = bit_en &&  bit_in && (ones == 3'd6);
    assign body_ev  = accept && (fill == FULL);
    assign body_bit = dly[DLY-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones <= 3'd0;
            dly  <= '0;
            fill <= '0;
        end else begin
            if (bit_en) begin
                ones <= bit_in ? ((ones == 3'd7) ? 3'd7 : ones + 3'd1) : 3'd0;
            end
            if (flag_ev || abort_ev) begin
                fill <= '0;
            end else if (accept) begin
                dly  <= {dly[DLY-2:0], bit_in};
                fill <= (fill == FULL) ? fill : fill + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hdlc_rx_crc.sv
// Serial check register, ones preset, first bit treated as highest term.
module hdlc_rx_crc
    import hdlc_rx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic din,
    output logic ok
);
    localparam logic [W-1:0] POLY = W'(crc_poly(W));
    localparam logic [W-1:0] RES  = W'(crc_residue(W));

    logic [W-1:0] crc;
    logic         fb;

    assign fb = crc[W-1] ^ din;
    assign ok = (crc == RES);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            crc <= '1;
        end else if (en) begin
            crc <= {crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
    end
endmodule

// File: rtl/hdlc_rx_octet.sv
// Octet packing (first bit = bit 0), holdback of the check octets,
// and the length facts needed at the closing flag.
module hdlc_rx_octet #(
    parameter int NB       = 2,
    parameter int MIN_BITS = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic       din,
    output logic       byte_ev,
    output logic [7:0] byte_out,
    output logic       short_fr,
    output logic       misal
);
    localparam int CW = $clog2(NB + 1);
    localparam int BW = $clog2(MIN_BITS + 1);
    localparam logic [CW-1:0] HFULL = CW'(NB);
    localparam logic [BW-1:0] MINV  = BW'(MIN_BITS);

    logic [7:0]      sr;
    logic [2:0]      pos;
    logic [CW-1:0]   hcnt;
    logic [BW-1:0]   bcnt;
    logic [8*NB-1:0] hold;
    logic [7:0]      new_byte;
    logic            push;
    logic            full;

    assign new_byte = {din, sr[7:1]};
    assign push     = en && (pos == 3'd7);
    assign full     = (hcnt == HFULL);
    assign byte_ev  = push && full;
    assign byte_out = hold[7:0];
    assign short_fr = (bcnt != MINV);
    assign misal    = (pos != 3'd0);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sr   <= '0;
            pos  <= '0;
            hcnt <= '0;
            bcnt <= '0;
            hold <= '0;
        end else if (en) begin
            sr  <= new_byte;
            pos <= pos + 3'd1;
            if (bcnt != MINV) begin
                bcnt <= bcnt + 1'b1;
            end
            if (push) begin
                if (full) begin
                    hold <= {new_byte, hold[8*NB-1:8]};
                end else begin
                    hold[8*hcnt +: 8] <= new_byte;
                    hcnt <= hcnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
#(
    parameter int FCS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_en,
    input  logic            bit_in,
    output logic            out_valid,
    output logic [7:0]      out_data,
    output logic            out_sof,
    output logic            out_end,
    output logic [ST_W-1:0] out_stat
);
    localparam int NB       = FCS_W / 8;
    localparam int MIN_BITS = FCS_W + 16;

    rx_state_e  state, state_nx;
    logic       flag_ev, abort_ev, body_ev, body_bit, body_go, clr;
    logic       crc_ok, byte_ev, short_fr, misal, sent;
    logic [7:0] byte_out;

    assign body_go = body_ev && (state != S_HUNT);
    assign clr     = flag_ev || abort_ev;

    hdlc_rx_line #(.DLY(FLAG_DELAY)) u_line (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .flag_ev(flag_ev), .abort_ev(abort_ev),
        .body_ev(body_ev), .body_bit(body_bit)
    );

    hdlc_rx_crc #(.W(FCS_W)) u_crc (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(body_go),
        .din(body_bit), .ok(crc_ok)
    );

    hdlc_rx_octet #(.NB(NB), .MIN_BITS(MIN_BITS)) u_oct (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(body_go), .din(body_bit),
        .byte_ev(byte_ev), .byte_out(byte_out),
        .short_fr(short_fr), .misal(misal)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            S_HUNT: if (flag_ev) state_nx = S_SYNC;
            S_SYNC: begin
                if (abort_ev)     state_nx = S_HUNT;
                else if (body_go) state_nx = S_BODY;
            end
            S_BODY: begin
                if (flag_ev)       state_nx = S_SYNC;
                else if (abort_ev) state_nx = S_HUNT;
            end
            default: state_nx = S_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_HUNT;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sof   <= 1'b0;
            out_end   <= 1'b0;
            out_stat  <= '0;
            sent      <= 1'b0;
        end else begin
            out_valid <= byte_ev;
            out_sof   <= byte_ev && !sent;
            if (byte_ev) out_data <= byte_out;
            sent      <= clr ? 1'b0 : (sent || byte_ev);
            out_end   <= (state == S_BODY) && clr;
            out_stat  <= '0;
            if (state == S_BODY && abort_ev) begin
                out_stat[ST_ABORT] <= 1'b1;
            end else if (state == S_BODY && flag_ev) begin
                out_stat[ST_CRC]   <= !crc_ok;
                out_stat[ST_SHORT] <= short_fr;
                out_stat[ST_ALIGN] <= misal;
            end
        end
    end
endmodule

// File: rtl/hdlc_rx_check.sv
module hdlc_rx_check
    import hdlc_rx_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            bit_en,
    input logic            out_valid,
    input logic            out_sof,
    input logic            out_end,
    input logic [ST_W-1:0] out_stat,
    input rx_state_e       state
);
    a_r11_pulse_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_en) |-> (!out_valid && !out_end));

    a_r3_sof_carries_data: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    a_r4_data_end_apart: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_end);

    a_r5_stat_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !out_end |-> (out_stat == '0));

    a_r1_hunt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == S_HUNT && state == S_HUNT) |-> (!out_valid && !out_end));

    a_r6_abort_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (out_end && out_stat[ST_ABORT]) |-> $onehot0(out_stat));
endmodule

bind hdlc_rx_deframer hdlc_rx_check u_chk (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .out_valid(out_valid),
    .out_sof(out_sof), .out_end(out_end), .out_stat(out_stat), .state(state)
);

// File: tb/hdlc_rx_deframer_test.sv
module hdlc_rx_deframer_test;

    typedef struct {
        bit         skip;
        bit         is_end;
        logic [7:0] data;
        bit         sof;
        logic [3:0] stat;
        string      req;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en16 = 1'b0, en32 = 1'b0, bit_in = 1'b0;
    logic v16, s16, e16, v32, s32, e32;
    logic [7:0] d16, d32;
    logic [3:0] t16, t32;

    always #4 clk = ~clk;

    hdlc_rx_deframer #(.FCS_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .bit_en(en16), .bit_in(bit_in),
        .out_valid(v16), .out_data(d16), .out_sof(s16),
        .out_end(e16), .out_stat(t16));

    hdlc_rx_deframer #(.FCS_W(32)) uut32 (
        .clk(clk), .rst_n(rst_n), .bit_en(en32), .bit_in(bit_in),
        .out_valid(v32), .out_data(d32), .out_sof(s32),
        .out_end(e32), .out_stat(t32));

    item_t q16[$];
    item_t q32[$];
    int checks = 0, fails = 0;
    int cur_w = 16;
    bit body[0:2047];
    int nb = 0;
    int ones_tx = 0;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic push_item(input bit skip, input bit is_end, input logic [7:0] d,
                             input bit sof, input logic [3:0] st, input string req);
        item_t it;
        it.skip = skip; it.is_end = is_end; it.data = d;
        it.sof = sof; it.stat = st; it.req = req;
        if (cur_w == 32) q32.push_back(it);
        else             q16.push_back(it);
    endtask

    task automatic pop_item(input int w);
        if (w == 32) void'(q32.pop_front());
        else         void'(q16.pop_front());
    endtask

    task automatic mon(input int w, input logic v, input logic [7:0] d, input logic s,
                       input logic e, input logic [3:0] st);
        item_t it;
        int    n;
        if (!v && !e) return;
        n = (w == 32) ? q32.size() : q16.size();
        checks++;
        if (n == 0) begin
            fails++;
            $display("FAIL R9 w=%0d unexpected output: got valid=%0b end=%0b expected none", w, v, e);
            return;
        end
        it = (w == 32) ? q32[0] : q16[0];
        if (v) begin
            if (it.skip) return;
            if (it.is_end) begin
                fails++;
                $display("FAIL R4 w=%0d (%s) extra octet: got %h expected end", w, it.req, d);
            end else begin
                if (d !== it.data || s !== it.sof) begin
                    fails++;
                    $display("FAIL R3 w=%0d (%s) octet: got %h sof %0b expected %h sof %0b",
                             w, it.req, d, s, it.data, it.sof);
                end
                pop_item(w);
            end
        end else begin
            if (!it.is_end) begin
                fails++;
                $display("FAIL R4 w=%0d (%s) early end: got end expected octet %h", w, it.req, it.data);
                while (((w == 32) ? q32.size() : q16.size()) > 0 &&
                       !((w == 32) ? q32[0].is_end : q16[0].is_end)) pop_item(w);
                if (((w == 32) ? q32.size() : q16.size()) > 0) pop_item(w);
            end else begin
                if (st !== it.stat) begin
                    fails++;
                    $display("FAIL %s w=%0d status: got %b expected %b", it.req, w, st, it.stat);
                end
                pop_item(w);
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            mon(16, v16, d16, s16, e16, t16);
            mon(32, v32, d32, s32, e32, t32);
        end
    end

    // one strobed bit; the idle cycle carries the inverted value (R11)
    task automatic tx_raw(input bit b);
        @(negedge clk);
        bit_in = b;
        if (cur_w == 32) en32 = 1'b1; else en16 = 1'b1;
        @(negedge clk);
        en16 = 1'b0; en32 = 1'b0;
        bit_in = ~b;
    endtask

    task automatic tx_flag();
        tx_raw(1'b0);
        for (int i = 0; i < 6; i++) tx_raw(1'b1);
        tx_raw(1'b0);
        ones_tx = 0;
    endtask

    task automatic tx_raw_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) tx_raw(v[i]);
    endtask

    task automatic tx_stuffed(input bit b);
        tx_raw(b);
        if (b) ones_tx++; else ones_tx = 0;
        if (ones_tx == 5) begin
            tx_raw(1'b0);
            ones_tx = 0;
        end
    endtask

    task automatic add_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            body[nb] = v[i];
            nb++;
        end
    endtask

    task automatic add_fcs();
        logic [31:0] c, mask, poly;
        bit fb;
        mask = (cur_w == 32) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        poly = (cur_w == 32) ? 32'h04C1_1DB7 : 32'h0000_1021;
        c = mask;
        for (int i = 0; i < nb; i++) begin
            fb = c[cur_w-1] ^ body[i];
            c = (c << 1) & mask;
            if (fb) c = c ^ poly;
        end
        for (int i = cur_w - 1; i >= 0; i--) begin
            body[nb] = ~c[i];
            nb++;
        end
    endtask

    // appends the check, predicts the outputs, sends body and closing flag
    task automatic send_frame(input bit corrupt, input string req);
        int nexp;
        bit shrt, mis;
        logic [7:0] d;
        add_fcs();
        if (corrupt) body[5] = ~body[5];
        shrt = (nb < cur_w + 16);
        mis  = (nb % 8) != 0;
        nexp = nb / 8 - cur_w / 8;
        for (int k = 0; k < nexp; k++) begin
            for (int j = 0; j < 8; j++) d[j] = body[8*k + j];
            push_item(1'b0, 1'b0, d, k == 0, 4'b0000, req);
        end
        push_item(1'b0, 1'b1, 8'h00, 1'b0, {mis, shrt, 1'b0, corrupt}, req);
        for (int i = 0; i < nb; i++) tx_stuffed(body[i]);
        tx_flag();
        nb = 0;
    endtask

    task automatic send_abort(input string req);
        push_item(1'b1, 1'b1, 8'h00, 1'b0, 4'b0010, req);
        for (int i = 0; i < nb; i++) tx_stuffed(body[i]);
        for (int i = 0; i < 8; i++) tx_raw(1'b1);
        nb = 0;
        ones_tx = 0;
    endtask

    task automatic expect_drained(input string req);
        repeat (10) @(negedge clk);
        checks++;
        if (q16.size() != 0 || q32.size() != 0) begin
            fails++;
            $display("FAIL %s pending items: got %0d/%0d expected 0/0", req, q16.size(), q32.size());
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R10 watchdog: got no completion expected end of stimulus");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        checks++;
        if (v16 || e16 || s16 || t16 != 0 || v32 || e32 || s32 || t32 != 0) begin
            fails++;
            $display("FAIL R10 outputs in reset: got %b%b%b%b expected 0000", v16, e16, v32, e32);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (v16 || e16 || t16 != 0 || v32 || e32 || t32 != 0) begin
            fails++;
            $display("FAIL R10 outputs after reset: got %b%b%b%b expected 0000", v16, e16, v32, e32);
        end

        // R1: noise before synchronisation
        tx_raw_byte(8'hA5); tx_raw_byte(8'h3C);
        expect_drained("R1");
        tx_flag();

        add_byte(8'h03); add_byte(8'h3F); add_byte(8'h11); add_byte(8'h22);
        send_frame(1'b0, "R3");
        add_byte(8'hFF); add_byte(8'h7E); add_byte(8'h3E); add_byte(8'hFC); add_byte(8'h1F);
        send_frame(1'b0, "R2");
        add_byte(8'h10); add_byte(8'h20); add_byte(8'h30);
        send_frame(1'b1, "R5");
        add_byte(8'h5A);
        send_frame(1'b0, "R7");
        add_byte(8'h81); add_byte(8'h42); add_byte(8'hC3);
        body[nb] = 1'b1; body[nb+1] = 1'b0; body[nb+2] = 1'b1; nb += 3;
        send_frame(1'b0, "R8");

        // R9: repeated flags only
        tx_flag(); tx_flag(); tx_flag();
        expect_drained("R9");

        add_byte(8'h55); add_byte(8'h66); add_byte(8'h77);
        send_abort("R6");
        tx_raw_byte(8'h00); tx_raw_byte(8'h81);
        expect_drained("R6");
        tx_flag();

        for (int i = 0; i < 20; i++) add_byte(8'(i * 37 + 1));
        send_frame(1'b0, "R4");
        expect_drained("R4");

        // R12: 32-bit instance
        cur_w = 32;
        tx_raw_byte(8'h6C);
        tx_flag();
        add_byte(8'hF0); add_byte(8'h0F); add_byte(8'hFF); add_byte(8'h01); add_byte(8'h7E);
        send_frame(1'b0, "R12");
        add_byte(8'hAB); add_byte(8'hCD); add_byte(8'hEF);
        send_frame(1'b1, "R12");
        add_byte(8'h99);
        send_frame(1'b0, "R12");
        tx_flag();
        expect_drained("R12");

        summary();
    end
endmodule